// File: doc/BRIEF.md
# Receive Frame Position Tracker

This block follows the byte position inside every receive frame of a byte-wide, interleaved SONET/SDH stream. A frame holds `ROWS` rows. Each row is `COLS_PER_STS × NUM_STS` bytes long. With the defaults (48 interleaved STS-1s, 90 columns, 9 rows) a row is 4,320 bytes and a frame is 38,880 bytes. A frame-boundary pulse comes from an upstream framer. The block checks that each new pulse lands exactly one frame period after the previous one. When a pulse arrives early or late, the block reports it and realigns to that pulse.

From its row and column counters the block decodes the following marks for the datapath around it:
- strobes for the three framing and trace overhead groups at the start of the first row;
- a strobe for the section parity byte position;
- an enable and a reset for the frame-synchronous descrambler;
- a frame-start strobe.

A loopback mode replaces the external pulse with one that the block generates itself. In that mode the block runs at exactly one frame per period, whatever the external pulse does.

Timing: a pulse sampled in cycle n marks byte 0. The position outputs then show row 0, column 0 in cycle n+1, and every output is a decode of the registered position.

Top module: `rxfp_frame_tracker`

## Requirements
- R1: While reset is held, the tracker sits on the last byte of the frame (row `ROWS-1`, column `ROW_LEN-1`). At that point frame_start, misalign, all overhead strobes and scr_reset are 0, and scr_on is 1. The first clock after reset moves it to byte 0.
- R2: With no effective pulse, the column advances by one each clock and wraps to 0 after `ROW_LEN-1`. The row advances on each column wrap and wraps to 0 after `ROWS-1`, so one frame is `ROWS × ROW_LEN` clocks.
- R3: An external pulse sampled while the tracker is on the last byte of the frame raises no misalign, and counting continues at byte 0.
- R4: An external pulse sampled anywhere else, once the tracker has locked, raises misalign for exactly one cycle (the cycle that shows byte 0) and reloads the position to row 0, column 0.
- R5: The first pulse after reset locks the tracker and reloads the position, but never raises misalign, wherever it falls.
- R6: In row 0, oh_a1 is 1 for columns 0 to N-1, oh_a2 for columns N to 2N-1, and oh_c1 for columns 2N to 3N-1, where N = `NUM_STS`. At every other position these strobes are 0.
- R7: scr_on is 0 for row 0, columns 0 to 3N-1 (the bytes that are not descrambled), and 1 at every other position.
- R8: scr_reset is 1 only at row 0, column 3N, which is the first byte after the first-row overhead.
- R9: oh_b1 is 1 only at row 1, column 0.
- R10: While loopback_en is 1, frame_in has no effect. The tracker wraps only after the last byte of the frame, and misalign stays 0.
- R11: frame_start is 1 exactly in the cycles where the position is row 0, column 0, whether that position came from a natural wrap or from a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_in | input | 1 | External frame-boundary pulse; the byte sampled with it is byte 0 |
| loopback_en | input | 1 | Use the internally generated frame pulse and ignore frame_in |
| row_idx | output | $clog2(ROWS) | Current row |
| col_idx | output | $clog2(ROW_LEN) | Current byte within the row |
| frame_start | output | 1 | First byte of a frame |
| oh_a1 | output | 1 | First framing byte group |
| oh_a2 | output | 1 | Second framing byte group |
| oh_c1 | output | 1 | Trace/identifier byte group |
| oh_b1 | output | 1 | Section parity byte position |
| scr_on | output | 1 | Descrambler enabled for this byte |
| scr_reset | output | 1 | Reload the descrambler seed on this byte |
| misalign | output | 1 | A pulse arrived off the frame period |

## Verification
The bench builds the tracker with 2 interleaved channels, 4 columns per channel and 3 rows. That gives an 8-byte row and a 24-byte frame, so every position fits into a few dozen cycles. At this size the bench can place a pulse at every one of the 24 offsets in a frame. It can also run many full frames in both normal and loopback mode. It compares every output at every cycle against positions computed by division and remainder. Because the overhead groups are only 2 bytes wide, the edges of every group and the descrambler reset column are hit on each frame.

// File: rtl/rxfp_pkg.sv
package rxfp_pkg;

   // Decoded per-byte marks produced from the frame position.
   typedef struct packed {
      logic frame_start;
      logic a1;
      logic a2;
      logic c1;
      logic b1;
      logic scr_on;
      logic scr_reset;
   } rxfp_marks_t;

   // Overhead groups in row 0, in wire order.
   localparam int unsigned OH_GROUPS = 3;

endpackage

// File: rtl/rxfp_pos_counter.sv
module rxfp_pos_counter #(
   parameter int unsigned ROWS    = 9,
   parameter int unsigned ROW_LEN = 4320,
   localparam int unsigned ROW_W  = $clog2(ROWS),
   localparam int unsigned COL_W  = $clog2(ROW_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   output logic [ROW_W-1:0] row_q,
   output logic [COL_W-1:0] col_q,
   output logic             at_last
);

   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_LEN - 1);

   logic col_wrap;

   assign col_wrap = (col_q == COL_LAST);
   assign at_last  = col_wrap && (row_q == ROW_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= ROW_LAST;
         col_q <= COL_LAST;
      end else if (reload) begin
         row_q <= '0;
         col_q <= '0;
      end else if (col_wrap) begin
         col_q <= '0;
         row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
         col_q <= col_q + 1'b1;
      end
   end

endmodule

// File: rtl/rxfp_pulse_gate.sv
module rxfp_pulse_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_in,
   input  logic loopback_en,
   input  logic at_last,
   output logic pulse,
   output logic misalign_q
);

   logic locked_q;

   // In loopback the internal pulse coincides with the natural wrap.
   assign pulse = loopback_en ? at_last : frame_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q   <= 1'b0;
         misalign_q <= 1'b0;
      end else begin
         locked_q   <= locked_q | pulse;
         misalign_q <= pulse & locked_q & ~at_last & ~loopback_en;
      end
   end

endmodule

// File: rtl/rxfp_oh_decode.sv
module rxfp_oh_decode
   import rxfp_pkg::*;
#(
   parameter int unsigned NUM_STS = 48,
   parameter int unsigned ROWS    = 9,
   parameter int unsigned ROW_LEN = 4320,
   localparam int unsigned ROW_W  = $clog2(ROWS),
   localparam int unsigned COL_W  = $clog2(ROW_LEN)
) (
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   output rxfp_marks_t      marks
);

   localparam logic [COL_W-1:0] OH_END = COL_W'(OH_GROUPS * NUM_STS);

   logic                 row0;
   logic [OH_GROUPS-1:0] grp;

   assign row0 = (row == '0);

   for (genvar g = 0; g < OH_GROUPS; g++) begin : g_grp
      localparam logic [COL_W-1:0] LO = COL_W'(g * NUM_STS);
      localparam logic [COL_W-1:0] HI = COL_W'((g + 1) * NUM_STS);
      assign grp[g] = row0 && (col >= LO) && (col < HI);
   end

   always_comb begin
      marks             = '0;
      marks.frame_start = row0 && (col == '0);
      marks.a1          = grp[0];
      marks.a2          = grp[1];
      marks.c1          = grp[2];
      marks.b1          = (row == ROW_W'(1)) && (col == '0);
      marks.scr_on      = ~(row0 && (col < OH_END));
      marks.scr_reset   = row0 && (col == OH_END);
   end

endmodule

// File: rtl/rxfp_frame_tracker.sv
module rxfp_frame_tracker
   import rxfp_pkg::*;
#(
   parameter int unsigned NUM_STS      = 48,
   parameter int unsigned COLS_PER_STS = 90,
   parameter int unsigned ROWS         = 9,
   localparam int unsigned ROW_LEN     = NUM_STS * COLS_PER_STS,
   localparam int unsigned ROW_W       = $clog2(ROWS),
   localparam int unsigned COL_W       = $clog2(ROW_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_in,
   input  logic             loopback_en,
   output logic [ROW_W-1:0] row_idx,
   output logic [COL_W-1:0] col_idx,
   output logic             frame_start,
   output logic             oh_a1,
   output logic             oh_a2,
   output logic             oh_c1,
   output logic             oh_b1,
   output logic             scr_on,
   output logic             scr_reset,
   output logic             misalign
);

   if (ROWS < 2) begin : g_bad_rows
      $error("rxfp_frame_tracker: ROWS must be at least 2");
   end
   if (COLS_PER_STS <= OH_GROUPS) begin : g_bad_cols
      $error("rxfp_frame_tracker: COLS_PER_STS must exceed the overhead groups");
   end
   if (NUM_STS < 1) begin : g_bad_sts
      $error("rxfp_frame_tracker: NUM_STS must be at least 1");
   end

   logic        at_last;
   logic        pulse;
   rxfp_marks_t marks;

   rxfp_pulse_gate gate_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_in    (frame_in),
      .loopback_en (loopback_en),
      .at_last     (at_last),
      .pulse       (pulse),
      .misalign_q  (misalign)
   );

   rxfp_pos_counter #(.ROWS(ROWS), .ROW_LEN(ROW_LEN)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .reload  (pulse),
      .row_q   (row_idx),
      .col_q   (col_idx),
      .at_last (at_last)
   );

   rxfp_oh_decode #(.NUM_STS(NUM_STS), .ROWS(ROWS), .ROW_LEN(ROW_LEN)) dec_i (
      .row   (row_idx),
      .col   (col_idx),
      .marks (marks)
   );

   assign frame_start = marks.frame_start;
   assign oh_a1       = marks.a1;
   assign oh_a2       = marks.a2;
   assign oh_c1       = marks.c1;
   assign oh_b1       = marks.b1;
   assign scr_on      = marks.scr_on;
   assign scr_reset   = marks.scr_reset;

endmodule

// File: rtl/rxfp_frame_tracker_chk.sv
module rxfp_frame_tracker_chk #(
   parameter int unsigned NUM_STS      = 48,
   parameter int unsigned COLS_PER_STS = 90,
   parameter int unsigned ROWS         = 9,
   localparam int unsigned ROW_LEN     = NUM_STS * COLS_PER_STS,
   localparam int unsigned ROW_W       = $clog2(ROWS),
   localparam int unsigned COL_W       = $clog2(ROW_LEN)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_in,
   input logic             loopback_en,
   input logic [ROW_W-1:0] row_idx,
   input logic [COL_W-1:0] col_idx,
   input logic             frame_start,
   input logic             oh_a1,
   input logic             oh_a2,
   input logic             oh_c1,
   input logic             oh_b1,
   input logic             scr_on,
   input logic             scr_reset,
   input logic             misalign
);

   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_LEN - 1);

   // R2: column steps by one when no pulse can reload it
   a_r2_col_advance: assert property (@(posedge clk) disable iff (!rst_n)
      ((!frame_in || loopback_en) && col_idx != COL_LAST)
      |=> (col_idx == $past(col_idx) + 1'b1));

   // R4: a sampled external pulse always lands on byte 0
   a_r4_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_in && !loopback_en) |=> (row_idx == '0 && col_idx == '0));

   // R10: loopback never reports misalignment
   a_r10_lb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      loopback_en |=> !misalign);

   // R11: the last byte is always followed by a frame start
   a_r11_start_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (row_idx == ROW_LAST && col_idx == COL_LAST) |=> frame_start);

   // R6, R8, R9: position strobes never overlap
   a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({oh_a1, oh_a2, oh_c1, oh_b1, scr_reset}));

   // R7: descrambling is off on every overhead group byte
   a_r7_scr_off_in_oh: assert property (@(posedge clk) disable iff (!rst_n)
      (oh_a1 || oh_a2 || oh_c1) |-> !scr_on);

   // R8: the descrambler reset directly follows the last trace byte
   a_r8_reset_after_c1: assert property (@(posedge clk) disable iff (!rst_n)
      scr_reset |-> $past(oh_c1));

   // R9: parity strobe follows the last byte of row 0
   a_r9_b1_after_row0: assert property (@(posedge clk) disable iff (!rst_n)
      oh_b1 |-> ($past(row_idx) == '0 && $past(col_idx) == COL_LAST));

endmodule

bind rxfp_frame_tracker rxfp_frame_tracker_chk #(
   .NUM_STS(NUM_STS), .COLS_PER_STS(COLS_PER_STS), .ROWS(ROWS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .loopback_en(loopback_en),
   .row_idx(row_idx), .col_idx(col_idx), .frame_start(frame_start),
   .oh_a1(oh_a1), .oh_a2(oh_a2), .oh_c1(oh_c1), .oh_b1(oh_b1),
   .scr_on(scr_on), .scr_reset(scr_reset), .misalign(misalign)
);

// File: tb/rxfp_frame_tracker_tb.sv
module rxfp_frame_tracker_tb_top;

   localparam int N    = 2;
   localparam int CPS  = 4;
   localparam int NR   = 3;
   localparam int RL   = N * CPS;
   localparam int FL   = RL * NR;
   localparam int LAST = FL - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_in = 1'b0;
   logic loopback_en = 1'b0;
   logic [$clog2(NR)-1:0] row_idx;
   logic [$clog2(RL)-1:0] col_idx;
   logic frame_start, oh_a1, oh_a2, oh_c1, oh_b1, scr_on, scr_reset, misalign;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   int  m_pos = LAST;
   bit  m_locked = 1'b0;
   bit  m_mis = 1'b0;

   always #10 clk = ~clk;

   rxfp_frame_tracker #(.NUM_STS(N), .COLS_PER_STS(CPS), .ROWS(NR)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .loopback_en(loopback_en),
      .row_idx(row_idx), .col_idx(col_idx), .frame_start(frame_start),
      .oh_a1(oh_a1), .oh_a2(oh_a2), .oh_c1(oh_c1), .oh_b1(oh_b1),
      .scr_on(scr_on), .scr_reset(scr_reset), .misalign(misalign)
   );

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at pos %0d: actual %0d expected %0d", req, m_pos, act, exp);
      end
   endtask

   task automatic check_all();
      int r, c;
      r = m_pos / RL;
      c = m_pos % RL;
      check("R2 row", int'(row_idx), r);
      check("R2 col", int'(col_idx), c);
      check("R11 frame_start", int'(frame_start), int'(m_pos == 0));
      check("R6 a1", int'(oh_a1), int'(r == 0 && c < N));
      check("R6 a2", int'(oh_a2), int'(r == 0 && c >= N && c < 2*N));
      check("R6 c1", int'(oh_c1), int'(r == 0 && c >= 2*N && c < 3*N));
      check("R7 scr_on", int'(scr_on), int'(!(r == 0 && c < 3*N)));
      check("R8 scr_reset", int'(scr_reset), int'(r == 0 && c == 3*N));
      check("R9 b1", int'(oh_b1), int'(r == 1 && c == 0));
      check("R4 misalign", int'(misalign), int'(m_mis));
   endtask

   // Drive one cycle at the falling edge, advance the model, check after the rise.
   task automatic step(input bit fin, input bit lb);
      bit pe;
      frame_in    = fin;
      loopback_en = lb;
      pe = lb ? (m_pos == LAST) : fin;
      m_mis = !lb && fin && m_locked && (m_pos != LAST);
      if (pe) m_locked = 1'b1;
      m_pos = pe ? 0 : ((m_pos == LAST) ? 0 : m_pos + 1);
      @(posedge clk);
      @(negedge clk);
      check_all();
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 row", int'(row_idx), NR - 1);
      check("R1 col", int'(col_idx), RL - 1);
      check("R1 frame_start", int'(frame_start), 0);
      check("R1 misalign", int'(misalign), 0);
      check("R1 strobes", int'({oh_a1, oh_a2, oh_c1, oh_b1, scr_reset}), 0);
      check("R1 scr_on", int'(scr_on), 1);
      rst_n = 1'b1;

      // R2, R6-R9, R11: free-running over several frames
      for (int i = 0; i < 3 * FL; i++) step(1'b0, 1'b0);

      // R5: first pulse off the period must not flag
      while (m_pos != 4) step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      check("R5 first pulse quiet", int'(misalign), 0);
      check("R5 reload", int'(col_idx), 0);

      // R3: pulse exactly on period
      while (m_pos != LAST) step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      check("R3 aligned quiet", int'(misalign), 0);

      // R4: exhaustive pulse offsets
      for (int k = 0; k < FL; k++) begin
         while (m_pos != k) step(1'b0, 1'b0);
         step(1'b1, 1'b0);
         check("R4 flag per offset", int'(misalign), int'(k != LAST));
         step(1'b0, 1'b0);
         check("R4 one cycle", int'(misalign), 0);
      end

      // R10: loopback ignores frame_in
      for (int i = 0; i < 4 * FL; i++) begin
         step(((i % 5) == 0) || ((i % 7) == 3), 1'b1);
         check("R10 no misalign", int'(misalign), 0);
      end

      // back to external pulses, aligned then misaligned
      while (m_pos != LAST) step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      for (int i = 0; i < 9; i++) step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      check("R11 start on reload", int'(frame_start), 1);
      for (int i = 0; i < FL; i++) step(1'b0, 1'b0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule